// File: doc/BRIEF.md
# Clock Generator Configuration Target with Staged Registers

This block is the two-wire serial configuration port of a line-locked pixel clock generator. It listens on the SCL and SDA lines, which are sampled into the system clock domain. It answers only the 7-bit device address formed from a fixed upper field and one low bit taken from a strap pin. A host can write or read one register or a run of consecutive registers. A read is started by writing the register index and then issuing a repeated START with the read bit set.

Four control registers are staged. A host write lands in a shadow copy, and the shadow copy is what the host reads back. The copy that drives the clock generator changes only when the host writes a recognised code to the write-only command register. The upper nibble of that code selects the loop group (feedback divider and loop control). The lower nibble selects the phase-delay control register. Each transfer produces a one-cycle strobe that resets the matching analog section. Read-only identity and lock-status registers complete the map.

Top module: `clkcfg_i2c_top`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits are 0100_11X, where X is the `addr_strap` level. For any other address it keeps SDA released for the rest of the transfer and writes nothing.
- R2: Every byte moves most-significant bit first. The eighth bit of the address byte is 0 for a write and 1 for a read.
- R3: A write of index then data updates the addressed register. A later read, made as an index write followed by a repeated START and a read address, returns that value.
- R4: In a write, each data byte after the first goes to the next index up, and every data byte is acknowledged.
- R5: In a read, each byte the host acknowledges is followed by the byte at the next index. A host NACK ends the read and leaves SDA released.
- R6: Indices 01h, 02h and 03h are staged. A host write changes their readback but not `loop_ctrl` or `fb_div` (12 bits: low 4 bits of index 03h above all of index 02h). Writing index 08h with upper nibble 5h copies the staged values out and raises `pll_rst_pulse` for exactly one cycle.
- R7: Index 05h is staged. Writing index 08h with lower nibble Ah copies it to `phase_ctrl` and raises `dpa_rst_pulse` for exactly one cycle.
- R8: Writing 5Ah to index 08h does both transfers, and both strobes rise in the same cycle. A code that matches neither nibble, such as 33h, raises no strobe and changes no output.
- R9: Index 10h reads 17h and index 11h reads 01h. Index 12h reads `dpa_locked` in bit 0, `pll_locked` in bit 1, and zero in bits 7:2.
- R10: After reset, indices 00h to 07h read 41h, 00h, FFh, 0Fh, 00h, 03h, 00h and 80h, and the outputs match those values.
- R11: Index 08h reads 00h. Writes to indices 10h to 12h, and reads and writes at unmapped indices, are acknowledged. Unmapped indices read 00h, and those writes change nothing.
- R12: The target pulls SDA low only during its own acknowledge bits and during the 0 bits of a read byte. It changes its SDA drive only while SCL is low, and it lets go after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_strap | input | 1 | Low address bit select |
| pll_locked | input | 1 | Loop lock status |
| dpa_locked | input | 1 | Phase-delay lock status |
| in_ctrl | output | 8 | Input control register (index 00h) |
| loop_ctrl | output | 8 | Active loop control (staged index 01h) |
| fb_div | output | 12 | Active feedback divider value (staged 02h/03h) |
| phase_ofs | output | 8 | Phase offset register (index 04h) |
| phase_ctrl | output | 8 | Active phase-delay control (staged index 05h) |
| out_en | output | 8 | Output enable register (index 06h) |
| osc_ctl | output | 8 | Oscillator divider and input select (index 07h) |
| pll_rst_pulse | output | 1 | One-cycle loop transfer and reset strobe |
| dpa_rst_pulse | output | 1 | One-cycle phase-delay transfer and reset strobe |

## Verification
Both staged transfers can fire in the same cycle, because one command byte carries both nibble keys. The bench provokes this by first changing the shadows of both groups and then writing 5Ah. It judges the result by counting the clock cycles in which both strobes are high together, which must be exactly one, and by requiring that both sets of active outputs have taken the staged values. Single-key codes and a non-matching code are sent as well, to show that each nibble acts alone.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned DW = 8;
  localparam logic [5:0] DEV_ADDR_HI = 6'b010011;

  localparam logic [7:0] IX_INPUT = 8'h00;
  localparam logic [7:0] IX_LOOP  = 8'h01;
  localparam logic [7:0] IX_FBLO  = 8'h02;
  localparam logic [7:0] IX_FBHI  = 8'h03;
  localparam logic [7:0] IX_PHOFS = 8'h04;
  localparam logic [7:0] IX_PHCTL = 8'h05;
  localparam logic [7:0] IX_OUTEN = 8'h06;
  localparam logic [7:0] IX_OSC   = 8'h07;
  localparam logic [7:0] IX_CMD   = 8'h08;
  localparam logic [7:0] IX_VER   = 8'h10;
  localparam logic [7:0] IX_REV   = 8'h11;
  localparam logic [7:0] IX_STAT  = 8'h12;

  localparam logic [7:0] RV_INPUT = 8'h41;
  localparam logic [7:0] RV_LOOP  = 8'h00;
  localparam logic [7:0] RV_FBLO  = 8'hFF;
  localparam logic [7:0] RV_FBHI  = 8'h0F;
  localparam logic [7:0] RV_PHOFS = 8'h00;
  localparam logic [7:0] RV_PHCTL = 8'h03;
  localparam logic [7:0] RV_OUTEN = 8'h00;
  localparam logic [7:0] RV_OSC   = 8'h80;

  localparam logic [7:0] ID_VER = 8'h17;
  localparam logic [7:0] ID_REV = 8'h01;

  localparam logic [3:0] KEY_LOOP  = 4'h5;
  localparam logic [3:0] KEY_PHASE = 4'hA;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_IDX, ST_IACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev_q;

  assign raw = {sda_in, scl_in};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-2:0], raw[l]};
    end
    assign synced[l] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  logic scl_s, scl_d, sda_d;
  assign scl_s = synced[0];
  assign sda_s = synced[1];
  assign scl_d = prev_q[0];
  assign sda_d = prev_q[1];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import clkcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] rd_idx,
  output logic          wr_en,
  output logic [DW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe
);
  tgt_state_e    st_q, st_n;
  logic [3:0]    bc_q, bc_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [DW-1:0] idx_q, idx_n;
  logic          rw_q, rw_n;
  logic          oe_q, oe_n;
  logic          hack_q, hack_n;

  always_comb begin
    st_n   = st_q;
    bc_n   = bc_q;
    sh_n   = sh_q;
    idx_n  = idx_q;
    rw_n   = rw_q;
    oe_n   = oe_q;
    hack_n = hack_q;
    wr_en  = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n = ST_ADDR;
      bc_n = 4'd0;
      oe_n = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_IDX, ST_WDAT: begin
          if (scl_rise && bc_q < 4'd8) begin
            sh_n = {sh_q[DW-2:0], sda_s};
            bc_n = bc_q + 4'd1;
          end else if (scl_fall && bc_q == 4'd8) begin
            bc_n = 4'd0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == {DEV_ADDR_HI, strap}) begin
                st_n = ST_AACK;
                oe_n = 1'b1;
                rw_n = sh_q[0];
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st_q == ST_IDX) begin
              idx_n = sh_q;
              st_n  = ST_IACK;
              oe_n  = 1'b1;
            end else begin
              wr_en = 1'b1;
              idx_n = idx_q + 8'd1;
              st_n  = ST_WACK;
              oe_n  = 1'b1;
            end
          end
        end
        ST_AACK, ST_IACK, ST_WACK: begin
          if (scl_fall) begin
            bc_n = 4'd0;
            if (st_q == ST_AACK && rw_q) begin
              st_n = ST_RDAT;
              sh_n = rd_data;
              oe_n = ~rd_data[7];
            end else begin
              oe_n = 1'b0;
              st_n = (st_q == ST_AACK) ? ST_IDX : ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bc_n = bc_q + 4'd1;
          end else if (scl_fall) begin
            if (bc_q == 4'd8) begin
              oe_n  = 1'b0;
              idx_n = idx_q + 8'd1;
              st_n  = ST_RACK;
            end else begin
              sh_n = {sh_q[DW-2:0], 1'b0};
              oe_n = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            hack_n = ~sda_s;
          end else if (scl_fall) begin
            if (hack_q) begin
              st_n = ST_RDAT;
              sh_n = rd_data;
              oe_n = ~rd_data[7];
              bc_n = 4'd0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bc_q   <= 4'd0;
      sh_q   <= '0;
      idx_q  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      hack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      bc_q   <= bc_n;
      sh_q   <= sh_n;
      idx_q  <= idx_n;
      rw_q   <= rw_n;
      oe_q   <= oe_n;
      hack_q <= hack_n;
    end
  end

  assign rd_idx  = idx_q;
  assign wr_idx  = idx_q;
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;

  // R12
  oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (st_q inside {ST_AACK, ST_IACK, ST_WACK, ST_RDAT}));
  // R12
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall || start_det || stop_det));
  // R1
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AACK && $past(st_q) == ST_ADDR) |-> ($past(sh_q[7:1]) == {DEV_ADDR_HI, strap}));
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (idx_q == $past(idx_q) + 8'd1));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import clkcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          pll_locked,
  input  logic          dpa_locked,
  output logic [DW-1:0] in_ctrl,
  output logic [DW-1:0] loop_ctrl,
  output logic [11:0]   fb_div,
  output logic [DW-1:0] phase_ofs,
  output logic [DW-1:0] phase_ctrl,
  output logic [DW-1:0] out_en,
  output logic [DW-1:0] osc_ctl,
  output logic          pll_pulse,
  output logic          dpa_pulse
);
  logic [DW-1:0] in_q, loop_sh, fblo_sh, fbhi_sh, phofs_q, phctl_sh, outen_q, osc_q;
  logic [DW-1:0] loop_w, fblo_w, phctl_w;
  logic [3:0]    fbhi_w;
  logic          pll_q, dpa_q;

  logic en_in, en_loop, en_fblo, en_fbhi, en_phofs, en_phctl, en_outen, en_osc;
  logic cmd_wr, go_loop, go_phase;

  always_comb begin
    en_in    = wr_en && (wr_idx == IX_INPUT);
    en_loop  = wr_en && (wr_idx == IX_LOOP);
    en_fblo  = wr_en && (wr_idx == IX_FBLO);
    en_fbhi  = wr_en && (wr_idx == IX_FBHI);
    en_phofs = wr_en && (wr_idx == IX_PHOFS);
    en_phctl = wr_en && (wr_idx == IX_PHCTL);
    en_outen = wr_en && (wr_idx == IX_OUTEN);
    en_osc   = wr_en && (wr_idx == IX_OSC);
    cmd_wr   = wr_en && (wr_idx == IX_CMD);
    go_loop  = cmd_wr && (wr_data[7:4] == KEY_LOOP);
    go_phase = cmd_wr && (wr_data[3:0] == KEY_PHASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q     <= RV_INPUT;
      loop_sh  <= RV_LOOP;
      fblo_sh  <= RV_FBLO;
      fbhi_sh  <= RV_FBHI;
      phofs_q  <= RV_PHOFS;
      phctl_sh <= RV_PHCTL;
      outen_q  <= RV_OUTEN;
      osc_q    <= RV_OSC;
    end else begin
      if (en_in)    in_q     <= wr_data;
      if (en_loop)  loop_sh  <= wr_data;
      if (en_fblo)  fblo_sh  <= wr_data;
      if (en_fbhi)  fbhi_sh  <= wr_data;
      if (en_phofs) phofs_q  <= wr_data;
      if (en_phctl) phctl_sh <= wr_data;
      if (en_outen) outen_q  <= wr_data;
      if (en_osc)   osc_q    <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_w  <= RV_LOOP;
      fblo_w  <= RV_FBLO;
      fbhi_w  <= RV_FBHI[3:0];
      phctl_w <= RV_PHCTL;
      pll_q   <= 1'b0;
      dpa_q   <= 1'b0;
    end else begin
      pll_q <= go_loop;
      dpa_q <= go_phase;
      if (go_loop) begin
        loop_w <= loop_sh;
        fblo_w <= fblo_sh;
        fbhi_w <= fbhi_sh[3:0];
      end
      if (go_phase) phctl_w <= phctl_sh;
    end
  end

  always_comb begin
    case (rd_idx)
      IX_INPUT: rd_data = in_q;
      IX_LOOP:  rd_data = loop_sh;
      IX_FBLO:  rd_data = fblo_sh;
      IX_FBHI:  rd_data = fbhi_sh;
      IX_PHOFS: rd_data = phofs_q;
      IX_PHCTL: rd_data = phctl_sh;
      IX_OUTEN: rd_data = outen_q;
      IX_OSC:   rd_data = osc_q;
      IX_VER:   rd_data = ID_VER;
      IX_REV:   rd_data = ID_REV;
      IX_STAT:  rd_data = {6'd0, pll_locked, dpa_locked};
      default:  rd_data = '0;
    endcase
  end

  assign in_ctrl    = in_q;
  assign loop_ctrl  = loop_w;
  assign fb_div     = {fbhi_w, fblo_w};
  assign phase_ofs  = phofs_q;
  assign phase_ctrl = phctl_w;
  assign out_en     = outen_q;
  assign osc_ctl    = osc_q;
  assign pll_pulse  = pll_q;
  assign dpa_pulse  = dpa_q;

  // R6
  loop_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_q |-> (loop_w == loop_sh && fblo_w == fblo_sh && fbhi_w == fbhi_sh[3:0]));
  // R6
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_q |-> ($stable(loop_w) && $stable(fblo_w) && $stable(fbhi_w)));
  // R7
  phase_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpa_q |-> (phctl_w == phctl_sh));
  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dpa_q |-> $stable(phctl_w));
  // R8
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_q || dpa_q) |-> $past(wr_en && wr_idx == IX_CMD));
  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_q |=> !pll_q);
endmodule

// File: rtl/clkcfg_i2c_top.sv
module clkcfg_i2c_top
  import clkcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          addr_strap,
  input  logic          pll_locked,
  input  logic          dpa_locked,
  output logic [7:0]    in_ctrl,
  output logic [7:0]    loop_ctrl,
  output logic [11:0]   fb_div,
  output logic [7:0]    phase_ofs,
  output logic [7:0]    phase_ctrl,
  output logic [7:0]    out_en,
  output logic [7:0]    osc_ctl,
  output logic          pll_rst_pulse,
  output logic          dpa_rst_pulse
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] rd_data, rd_idx, wr_idx, wr_data;
  logic          wr_en;

  i2c_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .strap(addr_strap), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfg_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .pll_locked(pll_locked), .dpa_locked(dpa_locked),
    .in_ctrl(in_ctrl), .loop_ctrl(loop_ctrl), .fb_div(fb_div),
    .phase_ofs(phase_ofs), .phase_ctrl(phase_ctrl), .out_en(out_en),
    .osc_ctl(osc_ctl), .pll_pulse(pll_rst_pulse), .dpa_pulse(dpa_rst_pulse)
  );
endmodule

// File: tb/tb_clkcfg_i2c_top.sv
module tb_clkcfg_i2c_top;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic strap = 1'b0;
  logic pll_lk = 1'b0;
  logic dpa_lk = 1'b0;
  logic sda_oe;
  wire  sda_line = ~(host_low | sda_oe);
  logic [7:0]  in_ctrl, loop_ctrl, phase_ofs, phase_ctrl, out_en, osc_ctl;
  logic [11:0] fb_div;
  logic pll_p, dpa_p;

  always #2 clk = ~clk;

  clkcfg_i2c_top dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(strap), .pll_locked(pll_lk), .dpa_locked(dpa_lk),
    .in_ctrl(in_ctrl), .loop_ctrl(loop_ctrl), .fb_div(fb_div),
    .phase_ofs(phase_ofs), .phase_ctrl(phase_ctrl), .out_en(out_en),
    .osc_ctl(osc_ctl), .pll_rst_pulse(pll_p), .dpa_rst_pulse(dpa_p)
  );

  int n_chk = 0, n_err = 0;
  int pll_cnt = 0, dpa_cnt = 0, both_cnt = 0;
  bit done = 0;
  logic [7:0] mdl [0:7];
  logic [7:0] w_loop, w_fblo, w_phctl;
  logic [3:0] w_fbhi;
  logic [7:0] rbuf [0:15];

  always @(negedge clk) begin
    if (pll_p) pll_cnt++;
    if (dpa_p) dpa_cnt++;
    if (pll_p && dpa_p) both_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] ix);
    if (ix < 8'h08) return mdl[ix[2:0]];
    case (ix)
      8'h10: return 8'h17;
      8'h11: return 8'h01;
      8'h12: return {6'd0, pll_lk, dpa_lk};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] ix, input logic [7:0] v);
    if (ix < 8'h08) mdl[ix[2:0]] = v;
    if (ix == 8'h08) begin
      if (v[7:4] == 4'h5) begin w_loop = mdl[1]; w_fblo = mdl[2]; w_fbhi = mdl[3][3:0]; end
      if (v[3:0] == 4'hA) w_phctl = mdl[5];
    end
  endtask

  task automatic check_outs(input string req);
    check({req, " in_ctrl"}, in_ctrl, mdl[0]);
    check({req, " loop_ctrl"}, loop_ctrl, w_loop);
    check({req, " fb_div"}, fb_div, {w_fbhi, w_fblo});
    check({req, " phase_ofs"}, phase_ofs, mdl[4]);
    check({req, " phase_ctrl"}, phase_ctrl, w_phctl);
    check({req, " out_en"}, out_en, mdl[6]);
    check({req, " osc_ctl"}, osc_ctl, mdl[7]);
  endtask

  task automatic qw(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    host_low = 0; scl = 1; qw(1);
    host_low = 1; qw(1);
    scl = 0; qw(1);
  endtask

  task automatic i2c_rstart();
    host_low = 0; qw(1);
    scl = 1; qw(1);
    host_low = 1; qw(1);
    scl = 0; qw(1);
  endtask

  task automatic i2c_stop();
    host_low = 1; qw(1);
    scl = 1; qw(1);
    host_low = 0; qw(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; qw(1);
      scl = 1; qw(2);
      scl = 0; qw(1);
    end
    host_low = 0; qw(1);
    scl = 1; qw(1);
    nack = sda_line; qw(1);
    scl = 0; qw(1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic last);
    host_low = 0;
    for (int i = 7; i >= 0; i--) begin
      qw(1);
      scl = 1; qw(1);
      b[i] = sda_line; qw(1);
      scl = 0;
    end
    qw(1);
    host_low = ~last; qw(1);
    scl = 1; qw(2);
    scl = 0; qw(1);
    host_low = 0;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {6'b010011, strap, rd};
  endfunction

  task automatic wr_seq(input logic [7:0] ix, input logic [7:0] v0, input logic [7:0] v1,
                        input logic [7:0] v2, input int n, input string req);
    logic nk;
    i2c_start();
    send_byte(dev(1'b0), nk); check({req, " addr ack"}, nk, 1'b0);
    send_byte(ix, nk);        check({req, " index ack"}, nk, 1'b0);
    send_byte(v0, nk);        check({req, " data ack"}, nk, 1'b0);
    if (n > 1) begin send_byte(v1, nk); check({req, " data ack"}, nk, 1'b0); end
    if (n > 2) begin send_byte(v2, nk); check({req, " data ack"}, nk, 1'b0); end
    i2c_stop();
    qw(1);
    model_wr(ix, v0);
    if (n > 1) model_wr(ix + 8'd1, v1);
    if (n > 2) model_wr(ix + 8'd2, v2);
    check({req, " sda released after stop (R12)"}, sda_oe, 1'b0);
  endtask

  task automatic rd_seq(input logic [7:0] ix, input int n, input string req);
    logic nk;
    i2c_start();
    send_byte(dev(1'b0), nk); check({req, " addr ack"}, nk, 1'b0);
    send_byte(ix, nk);        check({req, " index ack"}, nk, 1'b0);
    i2c_rstart();
    send_byte(dev(1'b1), nk); check({req, " read addr ack"}, nk, 1'b0);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i == n - 1);
    qw(1);
    check({req, " sda released after NACK (R5)"}, sda_oe, 1'b0);
    i2c_stop();
    qw(1);
    for (int i = 0; i < n; i++) check({req, " read data"}, rbuf[i], exp_rd(ix + 8'(i)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic nk;
    int sd;
    mdl[0] = 8'h41; mdl[1] = 8'h00; mdl[2] = 8'hFF; mdl[3] = 8'h0F;
    mdl[4] = 8'h00; mdl[5] = 8'h03; mdl[6] = 8'h00; mdl[7] = 8'h80;
    w_loop = 8'h00; w_fblo = 8'hFF; w_fbhi = 4'hF; w_phctl = 8'h03;
    sd = $urandom(32'd2718);
    repeat (5) @(negedge clk);
    rst_n = 1;
    qw(2);

    // R10 reset state at the outputs and through readback
    check("R10 sda_oe at reset", sda_oe, 1'b0);
    check_outs("R10");
    rd_seq(8'h00, 8, "R10 R5 R2");

    // R9 identity and status, asymmetric values expose bit order (R2)
    pll_lk = 1; dpa_lk = 0;
    rd_seq(8'h10, 3, "R9 R2");
    pll_lk = 0; dpa_lk = 1;
    rd_seq(8'h12, 1, "R9");

    // R1 address of the other strap value is ignored
    i2c_start();
    send_byte(8'h4E, nk); check("R1 foreign addr nack", nk, 1'b1);
    send_byte(8'h00, nk); check("R1 no ack after foreign addr", nk, 1'b1);
    send_byte(8'h55, nk); check("R1 no ack after foreign addr", nk, 1'b1);
    i2c_stop();
    rd_seq(8'h00, 1, "R1 foreign write ignored");
    strap = 1;
    i2c_start();
    send_byte(8'h4C, nk); check("R1 low-strap addr nack with strap high", nk, 1'b1);
    i2c_stop();
    wr_seq(8'h06, 8'hA5, 0, 0, 1, "R1 R3 strap high");
    rd_seq(8'h06, 1, "R1 R3 strap high");
    check_outs("R1 R3");
    strap = 0;

    // R4 sequential write into staged group, R6 hold
    wr_seq(8'h01, 8'h12, 8'h34, 8'h56, 3, "R4");
    rd_seq(8'h01, 3, "R4 R5 R6 shadow readback");
    check_outs("R6 outputs held");
    check("R6 no pll strobe yet", pll_cnt, 0);

    // R6 loop transfer
    wr_seq(8'h08, 8'h50, 0, 0, 1, "R6");
    check_outs("R6 after transfer");
    check("R6 pll strobe count", pll_cnt, 1);
    check("R6 dpa strobe count", dpa_cnt, 0);

    // R7 phase transfer
    wr_seq(8'h04, 8'h21, 8'h02, 0, 2, "R7 R4");
    check_outs("R7 held");
    wr_seq(8'h08, 8'h0A, 0, 0, 1, "R7");
    check_outs("R7 after transfer");
    check("R7 dpa strobe count", dpa_cnt, 1);
    check("R7 pll strobe count", pll_cnt, 1);

    // R8 both in same cycle, then a neutral code
    wr_seq(8'h01, 8'h77, 0, 0, 1, "R8");
    wr_seq(8'h05, 8'h01, 0, 0, 1, "R8");
    wr_seq(8'h08, 8'h5A, 0, 0, 1, "R8");
    check_outs("R8 both transfers");
    check("R8 same-cycle strobes", both_cnt, 1);
    wr_seq(8'h01, 8'h99, 0, 0, 1, "R8");
    wr_seq(8'h08, 8'h33, 0, 0, 1, "R8 neutral code");
    check_outs("R8 neutral code");
    check("R8 no extra pll strobe", pll_cnt, 2);
    check("R8 no extra dpa strobe", dpa_cnt, 2);

    // R11 read-only, write-only and unmapped indices
    wr_seq(8'h10, 8'h00, 8'hFF, 8'hFF, 3, "R11");
    rd_seq(8'h0F, 5, "R11");
    wr_seq(8'h40, 8'hC3, 0, 0, 1, "R11 unmapped");
    rd_seq(8'h40, 1, "R11 unmapped");
    check_outs("R11");

    // random phase
    for (int it = 0; it < 24; it++) begin
      int r;
      logic [7:0] ix, v;
      r = $urandom % 12;
      v = 8'($urandom);
      pll_lk = 1'($urandom); dpa_lk = 1'($urandom);
      if (r < 8) ix = 8'(r);
      else if (r == 8) ix = 8'h10 + 8'($urandom % 3);
      else if (r == 9) begin
        ix = 8'h08;
        case ($urandom % 4)
          0: v = 8'h50; 1: v = 8'h0A; 2: v = 8'h5A; default: ;
        endcase
      end else ix = 8'h13 + 8'($urandom % 236);
      wr_seq(ix, v, 0, 0, 1, "R3 R11 random");
      rd_seq(ix, 1, "R3 R9 R11 random");
      check_outs("R6 R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule